// File: doc/BRIEF.md
# DDR2 Burst Column Order Generator

This block expands one burst request into the sequence of column addresses a DDR2 device visits during a read or write burst, one address per beat. A request carries a starting column, a length select (4 or 8 beats) and an order select (sequential or interleaved). The generator walks the low column bits through a wrapped group of 4 or 8 addresses. The column bits above that group pass through unchanged.

Requests arrive on a valid/ready channel and beats leave on a second valid/ready channel. The downstream consumer may stall at any beat by dropping `beat_ready`. The current beat is then held steady until it is taken. While a burst is in flight, `cmd_ready` stays low, except in the cycle where the final beat is being accepted. A request taken in that cycle starts its first beat on the very next cycle, so consecutive bursts run with no empty cycle between them.

Top module: `bco_burst_order`

## Requirements
- R1: After reset, `beat_valid` is 0 and `cmd_ready` is 1.
- R2: With `cmd_ilv`=0 (sequential) and `cmd_len8`=0 (4 beats), column bits [1:0] on beat i equal (start[1:0] + i) mod 4; for example, start 2 gives 2,3,0,1.
- R3: With `cmd_ilv`=0 and `cmd_len8`=1 (8 beats), bits [1:0] count modulo 4 from start[1:0], and bit 2 equals start[2] on beats 0-3 and its inverse on beats 4-7; for example, start 1 gives 1,2,3,0,5,6,7,4 and start 7 gives 7,4,5,6,3,0,1,2.
- R4: With `cmd_ilv`=1 (interleaved), the ordered bits on beat i equal start XOR i. These are bits [2:0] for 8 beats and bits [1:0] for 4 beats; for example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R5: A start whose ordered bits are all 0 yields the ascending order 0..N-1 in both orders.
- R6: Column bits above the ordered group equal the starting column on every beat. The group is bits [1:0] for 4 beats and bits [2:0] for 8 beats, so bit 2 passes through in 4-beat bursts.
- R7: Each accepted request produces exactly N accepted beats, and `beat_last` is 1 on beat N-1 only.
- R8: Length, order and starting column are captured when the request is accepted. Changes on those inputs during the burst have no effect on its beats.
- R9: `cmd_ready` is 1 when no burst is in flight, or when the final beat is accepted in the same cycle. The first beat of an accepted request appears on the next cycle, with no gap after a preceding burst.
- R10: While `beat_valid`=1 and `beat_ready`=0, `beat_valid`, `beat_col` and `beat_last` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Burst request present |
| cmd_ready | output | 1 | Request accepted this cycle when valid |
| cmd_col | input | COL_W | Starting column |
| cmd_len8 | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| cmd_ilv | input | 1 | 1 = interleaved order, 0 = sequential order |
| beat_valid | output | 1 | Beat address present |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one of its burst |

## Verification
The bench runs directed bursts that reproduce the documented example orders for each length and order pair. These distinguish a modulo-4 wrap from a plain increment, and an XOR walk from a sequential one. Zero starts check that both orders collapse to the same ascending run, and starts with bit 2 set in 4-beat mode show whether bit 2 is wrongly folded into the group. Random requests with random consumer stalls and request fields that change mid-burst then exercise capture-at-accept, holding of a stalled beat, and chained bursts with no gap.

// File: rtl/bco_pkg.sv
package bco_pkg;
  localparam int unsigned GRP_W    = 3;
  localparam int unsigned LAST_L4  = 3;
  localparam int unsigned LAST_L8  = 7;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } ord_e;

  typedef struct packed {
    logic len8;
    ord_e ord;
  } burst_cfg_t;
endpackage

// File: rtl/bco_seq_ctrl.sv
module bco_seq_ctrl
  import bco_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             len8,
  input  logic             beat_ready,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             load,
  output logic [GRP_W-1:0] idx
);
  logic busy_q;
  logic [GRP_W-1:0] idx_q;
  logic [GRP_W-1:0] end_idx;

  assign end_idx    = len8 ? GRP_W'(LAST_L8) : GRP_W'(LAST_L4);
  assign beat_valid = busy_q;
  assign beat_last  = busy_q && (idx_q == end_idx);
  assign cmd_ready  = !busy_q || (beat_ready && beat_last);
  assign load       = cmd_valid && cmd_ready;
  assign idx        = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && beat_ready) begin
      if (beat_last) busy_q <= 1'b0;
      else           idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/bco_addr_map.sv
module bco_addr_map
  import bco_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] start_col,
  input  burst_cfg_t       cfg,
  input  logic [GRP_W-1:0] idx,
  output logic [COL_W-1:0] col
);
  logic [1:0] low2;
  logic       bit2;

  always_comb begin
    if (cfg.ord == ORD_XOR) low2 = start_col[1:0] ^ idx[1:0];
    else                    low2 = start_col[1:0] + idx[1:0];
    bit2 = start_col[2] ^ (cfg.len8 & idx[2]);
  end

  generate
    if (COL_W > GRP_W) begin : g_upper
      assign col = {start_col[COL_W-1:GRP_W], bit2, low2};
    end else begin : g_narrow
      assign col = {bit2, low2};
    end
  endgenerate
endmodule

// File: rtl/bco_burst_order.sv
module bco_burst_order
  import bco_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_len8,
  input  logic             cmd_ilv,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last
);
  logic             load;
  logic [GRP_W-1:0] idx;
  logic [COL_W-1:0] start_q;
  burst_cfg_t       cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cfg_q   <= '{len8: 1'b0, ord: ORD_SEQ};
    end else if (load) begin
      start_q  <= cmd_col;
      cfg_q.len8 <= cmd_len8;
      cfg_q.ord  <= ord_e'(cmd_ilv);
    end
  end

  bco_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .len8       (cfg_q.len8),
    .beat_ready (beat_ready),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .load       (load),
    .idx        (idx)
  );

  bco_addr_map #(.COL_W(COL_W)) u_map (
    .start_col (start_q),
    .cfg       (cfg_q),
    .idx       (idx),
    .col       (beat_col)
  );
endmodule

// File: rtl/bco_checker.sv
module bco_checker #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_last
);
  logic done;
  assign done = beat_valid && beat_ready && beat_last;

  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> cmd_ready);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_col) && $stable(beat_last)));

  a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_valid) |=> beat_valid);

  a_r7_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_valid) |=> !beat_valid);

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !done) |-> !cmd_ready);

  generate
    if (COL_W > 3) begin : g_up
      a_r6_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !beat_last) |=> $stable(beat_col[COL_W-1:3]));
    end
  endgenerate
endmodule

bind bco_burst_order bco_checker #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_col   (beat_col),
  .beat_last  (beat_last)
);

// File: tb/sim_bco_burst_order.sv
module sim_bco_burst_order;
  localparam int COL_W = 10;
  localparam time T_CLK = 10ns;

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic             last;
    logic [1:0]       tag;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_len8 = 0, cmd_ilv = 0, beat_ready = 0;
  logic [COL_W-1:0] cmd_col = '0;
  logic cmd_ready, beat_valid, beat_last;
  logic [COL_W-1:0] beat_col;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  ent_t q[$];
  bit prev_stall = 0;
  logic [COL_W-1:0] prev_col;
  logic prev_last;

  always #(T_CLK/2) clk = ~clk;

  bco_burst_order #(.COL_W(COL_W)) u0 (.*);

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, bit l8, bit il, int i);
    logic [COL_W-1:0] r = s;
    int grp = l8 ? 8 : 4;
    int sg  = l8 ? int'(s[2:0]) : int'(s[1:0]);
    int v;
    if (il) v = sg ^ i;
    else    v = (i < 4) ? ((sg & 4) | (((sg & 3) + i) % 4))
                        : (((sg & 4) ^ 4) | (((sg & 3) + i) % 4));
    if (grp == 8) r[2:0] = v[2:0];
    else          r[1:0] = v[1:0];
    return r;
  endfunction

  function automatic string tag_name(logic [1:0] t);
    case (t)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic monitor();
    logic [COL_W-1:0] lowmask;
    if (prev_stall) begin  // R10
      check(beat_valid && beat_col == prev_col && beat_last == prev_last, "R10", beat_col, prev_col);
    end
    if (q.size() > 0) check(beat_valid, "R9", beat_valid, 1);
    if (beat_valid) begin
      if (q.size() == 0) check(0, "R7", beat_valid, 0);
      else begin
        ent_t e = q[0];
        lowmask = (e.tag == 2'd0) ? COL_W'(3) : (e.tag == 2'd3 && e.col[2] == e.col[2] && !e.last) ? COL_W'(7) : COL_W'(7);
        check((beat_col & COL_W'(3)) == (e.col & COL_W'(3)) && beat_col[2] == e.col[2],
              tag_name(e.tag), beat_col[2:0], e.col[2:0]);
        check(beat_col[COL_W-1:3] == e.col[COL_W-1:3], "R6", beat_col, e.col);
        check(beat_last == e.last, "R7", beat_last, e.last);
        if (beat_ready) void'(q.pop_front());
      end
    end
    prev_stall = beat_valid && !beat_ready;
    prev_col   = beat_col;
    prev_last  = beat_last;
    if (cmd_valid && cmd_ready) begin
      int n = cmd_len8 ? 8 : 4;
      logic [1:0] t;
      bit zero = cmd_len8 ? (cmd_col[2:0] == 0) : (cmd_col[1:0] == 0);
      t = zero ? 2'd3 : cmd_ilv ? 2'd2 : cmd_len8 ? 2'd1 : 2'd0;
      for (int i = 0; i < n; i++)
        q.push_back('{col: exp_col(cmd_col, cmd_len8, cmd_ilv, i), last: (i == n-1), tag: t});
    end
  endtask

  task automatic cyc(bit cv, logic [COL_W-1:0] c, bit l8, bit il, bit rr);
    @(negedge clk);
    cmd_valid = cv; cmd_col = c; cmd_len8 = l8; cmd_ilv = il; beat_ready = rr;
    #1;
    monitor();
  endtask

  task automatic drain();
    while (q.size() > 0) cyc(0, COL_W'($urandom), $urandom%2, $urandom%2, 1);
    cyc(0, '0, 0, 0, 1);
  endtask

  task automatic burst(logic [COL_W-1:0] c, bit l8, bit il);
    cyc(1, c, l8, il, 1);
    drain();
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    int bad0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(!beat_valid && cmd_ready, "R1", {beat_valid, cmd_ready}, 2'b01);
    @(negedge clk); rst_n = 1; #1;
    check(!beat_valid && cmd_ready, "R1", {beat_valid, cmd_ready}, 2'b01);

    burst(COL_W'('h2A2), 0, 0);  // R2: 2,3,0,1; R6 bit2 kept in 4-beat
    burst(COL_W'('h2A6), 0, 0);  // R6: bit2 set, 4-beat
    burst(COL_W'('h101), 1, 0);  // R3: 1,2,3,0,5,6,7,4
    burst(COL_W'('h104), 1, 0);  // R3
    burst(COL_W'('h107), 1, 0);  // R3: 7,4,5,6,3,0,1,2
    burst(COL_W'('h305), 1, 1);  // R4: 5,4,7,6,1,0,3,2
    burst(COL_W'('h303), 0, 1);  // R4: 3,2,1,0
    burst(COL_W'('h0F0), 1, 0);  // R5
    burst(COL_W'('h0F0), 1, 1);  // R5
    burst(COL_W'('h0F4), 0, 1);  // R5 with bit2 passing

    // R8: request fields toggle while a burst runs
    bad0 = n_bad;
    cyc(1, COL_W'('h1C3), 1, 0, 1);
    for (int i = 0; i < 7; i++) cyc(0, COL_W'($urandom), i%2, ~i%2, 1);
    drain();
    check(n_bad == bad0, "R8", n_bad - bad0, 0);

    // R9: chained requests with ready held high
    for (int i = 0; i < 40; i++) cyc(1, COL_W'($urandom), $urandom%2, $urandom%2, 1);
    drain();

    // random traffic with stalls (R7, R8, R10)
    for (int i = 0; i < 4000; i++)
      cyc(($urandom%10) < 6, COL_W'($urandom), $urandom%2, $urandom%2, ($urandom%4) != 0);
    drain();
    finish_run();
  end
endmodule